// File: doc/BRIEF.md
# Fully Associative Translation Cache with Least-Recently-Used Replacement

This block holds recent translations from 20-bit virtual page numbers to 12-bit physical frame numbers. Each lookup compares the incoming page number against every valid slot at once. On a hit the frame comes back in the same cycle. On a miss the block stops taking lookups and asks an external table walker for the translation. It then returns the walker's answer to the requester. A good answer is installed in a victim slot. A fault is only passed on.

Replacement is true least-recently-used. Each slot has an age counter, and the slot counts form a permutation of 0..ENTRIES-1. Accessing a slot sets its age to zero and increments every slot that was younger than the accessed slot's old age. The victim is the lowest-indexed empty slot if one exists. Otherwise it is the slot whose age is ENTRIES-1.

A control state machine runs the miss sequence.
- State names:
  - S_IDLE: accepts lookups.
  - S_WALK: requests the translation.
  - S_INSTALL: reports success and writes the entry.
  - S_FAULT: reports a fault.
- Transitions:
  - Idle to walk on a lookup that misses.
  - Walk to install on a fill without fault.
  - Walk to fault on a fill with fault.
  - Install to idle, and fault to idle, each after one cycle.

A flush input clears the whole table in one cycle.

Top module: `tlb_fa_lru`

## Requirements
- R1: After reset every slot is empty, `lk_ready` is 1, and `hit`, `walk_req` and `done_valid` are 0.
- R2: A lookup is accepted when `lk_valid` and `lk_ready` are both 1. If an accepted page number matches a valid slot, `hit` is 1 in that same cycle and `hit_pfn` carries that slot's frame. At most one slot ever matches a given page number.
- R3: An accepted lookup that matches no valid slot gives `hit`=0. From the next cycle `walk_req` is 1 and `walk_vpn` equals the missed page number. Both hold steady until a cycle with `fill_valid`=1.
- R4: `lk_ready` is 0 from the cycle after a miss until the block is back in S_IDLE. While it is 0, `hit` stays 0 whatever `lk_valid` and `lk_vpn` do.
- R5: A fill with `fill_fault`=0 makes `done_valid`=1, `done_fault`=0 and `done_pfn`=`fill_pfn` in the next cycle, for exactly one cycle. The pair is installed at the end of that cycle, so a later lookup of that page hits with that frame.
- R6: A fill with `fill_fault`=1 makes `done_valid`=1 and `done_fault`=1 for one cycle. Nothing is installed and the ages are not changed, so a repeat lookup of that page misses again.
- R7: While any slot is empty, a miss fills the lowest-indexed empty slot, so no valid translation is evicted before the table is full.
- R8: When the table is full, a miss evicts the least recently used translation. Both hits and installs count as uses.
- R9: `flush`=1 for one cycle empties every slot and resets the ages. In that cycle `lk_ready` is 0. A walk in progress continues and still installs its result. A flush in the install cycle itself drops that install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ready | output | 1 | Block is idle and accepts a lookup |
| hit | output | 1 | Accepted lookup matched a slot |
| hit_pfn | output | 12 | Frame number of the matching slot |
| walk_req | output | 1 | Translation request to the walker |
| walk_vpn | output | 20 | Page number being walked |
| fill_valid | input | 1 | Walker response strobe |
| fill_fault | input | 1 | Walker response is a fault |
| fill_pfn | input | 12 | Frame number from the walker |
| done_valid | output | 1 | Miss outcome available (one cycle) |
| done_fault | output | 1 | Miss outcome is a fault |
| done_pfn | output | 12 | Frame number for the missed page |

## Verification
The bench keeps its own model of slots and ages. It drives a small pool of page numbers so that hits, misses and evictions interleave, and it injects faults.

Replacement bugs show up as a hit where the model expects a miss, or the reverse:
- A design that evicts valid slots while empty slots remain, or that ignores hits when updating ages, evicts the wrong page.
- A design that installs on a fault keeps a page the model expects to miss.

The bench also checks the following:
- It holds a lookup during a walk, which catches a design that answers while stalled.
- It flushes in the middle of a walk, which catches a design that loses the pending install or keeps stale slots.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WALK,
        S_INSTALL,
        S_FAULT
    } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int N  = 16,
    parameter int VW = 20,
    parameter int PW = 12,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [VW-1:0] wr_vpn,
    input  logic [PW-1:0] wr_pfn,
    input  logic [VW-1:0] cmp_vpn,
    output logic          hit_any,
    output logic [IW-1:0] hit_idx,
    output logic [PW-1:0] hit_pfn,
    output logic [N-1:0]  valid
);
    logic [VW-1:0] vpn_q [N];
    logic [PW-1:0] pfn_q [N];
    logic [N-1:0]  match;

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid[i] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                valid[i] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IW'(i)) begin
                vpn_q[i] <= wr_vpn;
                pfn_q[i] <= wr_pfn;
            end
        end
        assign match[i] = valid[i] && (vpn_q[i] == cmp_vpn);
    end

    always_comb begin
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_idx = hit_idx | IW'(i);
                hit_pfn = hit_pfn | pfn_q[i];
            end
        end
    end
    assign hit_any = |match;

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid,
    output logic [IW-1:0] victim_idx
);
    logic [IW-1:0] age_q [N];
    logic [IW-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    for (genvar i = 0; i < N; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                age_q[i] <= IW'(i);
            end else if (touch) begin
                if (touch_idx == IW'(i)) begin
                    age_q[i] <= '0;
                end else if (age_q[i] < touched_age) begin
                    age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                victim_idx = IW'(i);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] == IW'(N - 1)) victim_idx = IW'(i);
            end
        end
    end

    logic [(1<<IW)-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) seen[age_q[i]] = 1'b1;
    end

    AST_AGES_PERMUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == N); // R8
endmodule

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 12,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_ready,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic             fill_fault,
    input  logic [PFN_W-1:0] fill_pfn,
    output logic             done_valid,
    output logic             done_fault,
    output logic [PFN_W-1:0] done_pfn
);
    tlb_state_e       state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pfn_q;
    logic [IW-1:0]    victim_q;

    logic             hit_any;
    logic [IW-1:0]    hit_idx;
    logic [IW-1:0]    victim_idx;
    logic [ENTRIES-1:0] valid_vec;
    logic             accept, miss_take, install, touch;
    logic [IW-1:0]    touch_idx;

    assign lk_ready  = (state_q == S_IDLE) && !flush;
    assign accept    = lk_valid && lk_ready;
    assign hit       = accept && hit_any;
    assign miss_take = accept && !hit_any;
    assign install   = (state_q == S_INSTALL) && !flush;
    assign touch     = hit || install;
    assign touch_idx = hit ? hit_idx : victim_q;

    tlb_cam #(.N(ENTRIES), .VW(VPN_W), .PW(PFN_W)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (install),
        .wr_idx  (victim_q),
        .wr_vpn  (vpn_q),
        .wr_pfn  (pfn_q),
        .cmp_vpn (lk_vpn),
        .hit_any (hit_any),
        .hit_idx (hit_idx),
        .hit_pfn (hit_pfn),
        .valid   (valid_vec)
    );

    tlb_lru #(.N(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .valid      (valid_vec),
        .victim_idx (victim_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (miss_take) state_d = S_WALK;
            S_WALK:    if (fill_valid) state_d = fill_fault ? S_FAULT : S_INSTALL;
            S_INSTALL: state_d = S_IDLE;
            S_FAULT:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q    <= '0;
            pfn_q    <= '0;
            victim_q <= '0;
        end else begin
            if (miss_take) begin
                vpn_q    <= lk_vpn;
                victim_q <= victim_idx;
            end
            if (state_q == S_WALK && fill_valid) pfn_q <= fill_pfn;
        end
    end

    always_comb begin
        walk_req   = (state_q == S_WALK);
        walk_vpn   = vpn_q;
        done_valid = (state_q == S_INSTALL) || (state_q == S_FAULT);
        done_fault = (state_q == S_FAULT);
        done_pfn   = pfn_q;
    end

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !fill_valid |=> walk_req && $stable(walk_vpn)); // R3
    AST_WALK_FROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req) |-> $past(lk_valid) && !$past(hit)); // R3
    AST_STALL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req || done_valid) |-> !hit); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R5
    AST_INSTALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_fault && !flush |=> valid_vec[$past(victim_q)]); // R5
    AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_fault && !flush |=> $stable(valid_vec)); // R6
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_vec == '0); // R9
endmodule

// File: tb/tb_tlb_fa_lru.sv
`timescale 1ns/1ps
module tb_tlb_fa_lru;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_ready, hit, walk_req, done_valid, done_fault;
    logic [11:0] hit_pfn, done_pfn, fill_pfn = '0;
    logic [19:0] walk_vpn;
    logic        fill_valid = 1'b0, fill_fault = 1'b0;

    always #2 clk = ~clk;

    tlb_fa_lru #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
        .hit(hit), .hit_pfn(hit_pfn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_pfn(fill_pfn),
        .done_valid(done_valid), .done_fault(done_fault), .done_pfn(done_pfn)
    );

    int total = 0, bad = 0;
    logic [19:0] m_vpn [N];
    logic [11:0] m_pfn [N];
    logic        m_val [N];
    int          m_age [N];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] walk_frame(input logic [19:0] v);
        return v[11:0] ^ 12'h5a5 ^ {4'h0, v[19:12]};
    endfunction

    function automatic int model_find(input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // R7 lowest empty slot first, else R8 oldest age
    function automatic int model_victim();
        for (int i = 0; i < N; i++) if (!m_val[i]) return i;
        for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
        return 0;
    endfunction

    task automatic model_touch(input int k);
        int old;
        old = m_age[k];
        for (int i = 0; i < N; i++) begin
            if (i == k) m_age[i] = 0;
            else if (m_age[i] < old) m_age[i]++;
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_val[i] = 1'b0;
            m_age[i] = i;
        end
    endtask

    task automatic lookup(input logic [19:0] v, input bit fault, input int wait_cyc,
                          input bit mid_flush, input string tag);
        int idx, vic;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vpn   = v;
        #1;
        idx = model_find(v);
        chk(lk_ready == 1'b1, {tag, " R4 ready"}, lk_ready, 1);
        if (idx >= 0) begin
            chk(hit == 1'b1, {tag, " R2 hit"}, hit, 1);
            chk(hit_pfn == m_pfn[idx], {tag, " R2 pfn"}, hit_pfn, m_pfn[idx]);
            @(posedge clk);
            model_touch(idx);
            #1 lk_valid = 1'b0;
        end else begin
            chk(hit == 1'b0, {tag, " R3 miss"}, hit, 0);
            vic = model_victim();
            @(posedge clk);
            @(negedge clk);
            if (m_val[0]) lk_vpn = m_vpn[0];
            #1;
            chk(walk_req == 1'b1, {tag, " R3 walk_req"}, walk_req, 1);
            chk(walk_vpn == v, {tag, " R3 walk_vpn"}, walk_vpn, v);
            chk(lk_ready == 1'b0 && hit == 1'b0, {tag, " R4 stall"}, {lk_ready, hit}, 0);
            for (int c = 0; c < wait_cyc; c++) begin
                @(negedge clk);
                if (mid_flush && c == 0) flush = 1'b1;
                #1;
                chk(walk_req == 1'b1 && walk_vpn == v, {tag, " R3 hold"}, walk_req, 1);
                if (mid_flush && c == 0) begin
                    @(posedge clk);
                    model_clear();
                    #1 flush = 1'b0;
                end
            end
            @(negedge clk);
            lk_valid   = 1'b0;
            fill_valid = 1'b1;
            fill_fault = fault;
            fill_pfn   = walk_frame(v);
            @(negedge clk);
            fill_valid = 1'b0;
            #1;
            chk(done_valid == 1'b1, {tag, " R5 done"}, done_valid, 1);
            chk(done_fault == fault, fault ? {tag, " R6 fault"} : {tag, " R5 nofault"}, done_fault, fault);
            if (!fault) chk(done_pfn == walk_frame(v), {tag, " R5 pfn"}, done_pfn, walk_frame(v));
            @(posedge clk);
            if (!fault) begin
                m_val[vic] = 1'b1;
                m_vpn[vic] = v;
                m_pfn[vic] = walk_frame(v);
                model_touch(vic);
            end
            @(negedge clk);
            #1 chk(done_valid == 1'b0, {tag, " R5 pulse"}, done_valid, 0);
        end
    endtask

    task automatic do_flush(input logic [19:0] v);
        @(negedge clk);
        flush    = 1'b1;
        lk_valid = 1'b1;
        lk_vpn   = v;
        #1;
        chk(lk_ready == 1'b0 && hit == 1'b0, "R9 flush stalls", {lk_ready, hit}, 0);
        @(posedge clk);
        model_clear();
        #1;
        flush    = 1'b0;
        lk_valid = 1'b0;
    endtask

    bit finished = 1'b0;
    initial begin
        #(200000 * 4);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [19:0] pool [12];
        seed = 7;
        void'($urandom(seed));
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(lk_ready == 1'b1, "R1 ready", lk_ready, 1);
        chk(hit == 1'b0 && walk_req == 1'b0 && done_valid == 1'b0, "R1 idle",
            {hit, walk_req, done_valid}, 0);
        lk_valid = 1'b1;
        lk_vpn = 20'h00000;
        #1 chk(hit == 1'b0, "R1 empty", hit, 0);
        lk_valid = 1'b0;

        // R7: partial fill, then finish fill; all eight must still be resident
        for (int i = 0; i < 3; i++) lookup(20'h10000 + 20'(i), 1'b0, 1, 1'b0, "R7 fill");
        for (int i = 3; i < N; i++) lookup(20'h10000 + 20'(i), 1'b0, 0, 1'b0, "R7 fill");
        for (int i = 0; i < N; i++) lookup(20'h10000 + 20'(i), 1'b0, 0, 1'b0, "R7 resident");

        // R8: refresh the first page, then miss; second page is the victim
        lookup(20'h10000, 1'b0, 0, 1'b0, "R8 touch");
        lookup(20'h2abcd, 1'b0, 2, 1'b0, "R8 evict");
        lookup(20'h10001, 1'b0, 0, 1'b0, "R8 evicted");
        lookup(20'h10000, 1'b0, 0, 1'b0, "R8 kept");

        // R6: fault installs nothing, repeat lookup misses again
        lookup(20'h3ffff, 1'b1, 1, 1'b0, "R6 first");
        lookup(20'h3ffff, 1'b0, 0, 1'b0, "R6 repeat");

        // R9: flush empties; flush during a walk still installs
        do_flush(20'h10000);
        lookup(20'h10000, 1'b0, 0, 1'b0, "R9 after");
        lookup(20'h44444, 1'b0, 2, 1'b1, "R9 midwalk");
        lookup(20'h44444, 1'b0, 0, 1'b0, "R9 installed");
        lookup(20'h10000, 1'b0, 0, 1'b0, "R9 gone");

        for (int i = 0; i < 12; i++) pool[i] = 20'(($urandom() & 32'h000fff00) | 32'(i));
        for (int n = 0; n < 400; n++) begin
            int p;
            p = int'($urandom() % 12);
            if (($urandom() % 50) == 0) do_flush(pool[p]);
            else lookup(pool[p], ($urandom() % 8) == 0, int'($urandom() % 4), 1'b0, "R8 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule